// File: doc/BRIEF.md
# Register Bank Bus Slave

A 32-bit slave on a classic Wishbone-style bus. Each access is a single transfer: the master holds cycle and strobe until the acknowledge arrives. The block decodes the word address into one of three targets and completes the access on that target.

The first target is a small local register window. It holds read/write control registers, one read-only status word and one write-only command word. The second is a window that maps onto one external synchronous RAM. The third is a window that forwards the access to a downstream sub-bus slave and passes its handshake back. Any address outside these windows still completes. A read there returns zero and a write there changes nothing. A master can therefore never hang on a bad address.

Top module: `regbank_slave`

## Requirements
- R1: A read to an address outside every window is acknowledged one cycle after it is accepted, with all-zero data.
- R2: A write to an address outside every window is acknowledged one cycle after it is accepted and changes no register, RAM word or sub-bus state.
- R3: A read/write register (word index 0..N_RW-1 of the register window) returns the last value written to it. The read data comes from a registered stage and the acknowledge follows acceptance by exactly one cycle. Register writes are also acknowledged after one cycle, and all control registers read zero after reset.
- R4: Word index N_RW of the register window returns status_i and ignores writes. Word index N_RW+1 is write-only: a write updates cmd_o and a read returns zero.
- R5: A read in the RAM window raises ram_rd_o in the acceptance cycle only; ram_rd_o stays low for every other target. The next cycle returns ram_dat_i together with the acknowledge.
- R6: A write in the RAM window raises ram_we_o for exactly one cycle, in the cycle after acceptance. The acknowledge follows in the next cycle, two cycles after acceptance.
- R7: An access in the sub-bus window drives sub_cyc_o and sub_stb_o together from the cycle after acceptance until the cycle in which sub_ack_i is seen. During that time sub_we_o equals the write direction, sub_sel_o is all ones, and sub_adr_o and sub_dat_o carry the window offset and write data.
- R8: The bus acknowledge for a sub-bus access is sub_ack_i in the same cycle. Read data is sub_dat_i.
- R9: Every accepted access produces exactly one single-cycle acknowledge. After reset wb_ack_o, ram_we_o, sub_cyc_o, ctrl_o and cmd_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write when high |
| wb_adr_i | input | AW | Word address |
| wb_dat_i | input | DW | Write data |
| wb_ack_o | output | 1 | Acknowledge |
| wb_dat_o | output | DW | Read data |
| status_i | input | DW | Value of the read-only status word |
| ctrl_o | output | N_RW*DW | Control registers, index 0 in the low word |
| cmd_o | output | DW | Write-only command word |
| ram_adr_o | output | RAM_AW | RAM word address |
| ram_dat_o | output | DW | RAM write data |
| ram_rd_o | output | 1 | RAM read enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_dat_i | input | DW | RAM read data, one cycle after ram_rd_o |
| sub_cyc_o | output | 1 | Sub-bus cycle |
| sub_stb_o | output | 1 | Sub-bus strobe |
| sub_we_o | output | 1 | Sub-bus write |
| sub_sel_o | output | DW/8 | Sub-bus byte select |
| sub_adr_o | output | SUB_AW | Offset inside the sub-bus window |
| sub_dat_o | output | DW | Sub-bus write data |
| sub_ack_i | input | 1 | Sub-bus acknowledge |
| sub_dat_i | input | DW | Sub-bus read data |

## Verification
The bench uses the default parameters: an 8-bit word address, two control registers and a register window of four words at 0. The RAM window holds 16 words at 16 and the sub-bus window holds 128 words at 128. This layout leaves two unmapped gaps, 4..15 and 32..127, so the bench can probe every window edge (15/16, 31/32, 127/128 and 255) with real accesses. The sub-bus stub answers three cycles after acceptance. This keeps the sub-bus acknowledge apart in time from the one-cycle register path and the two-cycle RAM write path.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REG  = 2'd1,
    TGT_RAM  = 2'd2,
    TGT_SUB  = 2'd3
  } tgt_e;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int AW       = 8,
  parameter int REG_AW   = 2,
  parameter int REG_BASE = 0,
  parameter int RAM_AW   = 4,
  parameter int RAM_BASE = 16,
  parameter int SUB_AW   = 7,
  parameter int SUB_BASE = 128
) (
  input  logic [AW-1:0] adr_i,
  output tgt_e          tgt_o
);
  localparam logic [AW-1:0] REG_B = AW'(REG_BASE);
  localparam logic [AW-1:0] RAM_B = AW'(RAM_BASE);
  localparam logic [AW-1:0] SUB_B = AW'(SUB_BASE);

  logic hit_reg, hit_ram, hit_sub;
  assign hit_reg = adr_i[AW-1:REG_AW] == REG_B[AW-1:REG_AW];
  assign hit_ram = adr_i[AW-1:RAM_AW] == RAM_B[AW-1:RAM_AW];
  assign hit_sub = adr_i[AW-1:SUB_AW] == SUB_B[AW-1:SUB_AW];

  // windows are aligned and disjoint; order only settles a bad configuration
  always_comb begin
    if (hit_reg)      tgt_o = TGT_REG;
    else if (hit_ram) tgt_o = TGT_RAM;
    else if (hit_sub) tgt_o = TGT_SUB;
    else              tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/regbank_regs.sv
module regbank_regs #(
  parameter int DW     = 32,
  parameter int REG_AW = 2,
  parameter int N_RW   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] idx_i,
  input  logic [DW-1:0]     wdat_i,
  input  logic [DW-1:0]     status_i,
  output logic [N_RW*DW-1:0] ctrl_o,
  output logic [DW-1:0]     cmd_o,
  output logic [DW-1:0]     rval_o
);
  localparam int RO_IDX = N_RW;
  localparam int WO_IDX = N_RW + 1;

  logic [DW-1:0] rw_q [N_RW];
  logic [DW-1:0] cmd_q;

  for (genvar g = 0; g < N_RW; g++) begin : g_rw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                rw_q[g] <= '0;
      else if (wr_i && idx_i == REG_AW'(g))       rw_q[g] <= wdat_i;
    end
    assign ctrl_o[g*DW +: DW] = rw_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cmd_q <= '0;
    else if (wr_i && idx_i == REG_AW'(WO_IDX))  cmd_q <= wdat_i;
  end
  assign cmd_o = cmd_q;

  // write-only word and unused slots read zero
  always_comb begin
    rval_o = '0;
    for (int i = 0; i < N_RW; i++)
      if (idx_i == REG_AW'(i)) rval_o = rw_q[i];
    if (idx_i == REG_AW'(RO_IDX)) rval_o = status_i;
  end

  AST_CMD_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> $past(wr_i)); // R4
  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(wr_i)); // R2
endmodule

// File: rtl/regbank_ram_port.sv
module regbank_ram_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_start_i,
  input  logic wr_start_i,
  input  logic sel_i,
  output logic ram_rd_o,
  output logic ram_we_o,
  output logic rd_ack_o,
  output logic wr_ack_o
);
  logic we_q, dly_q, rack_q, wack_q;

  assign ram_rd_o = rd_start_i & sel_i;

  // two-phase write: strobe with the flag set, then clear it and acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      dly_q  <= 1'b0;
      rack_q <= 1'b0;
      wack_q <= 1'b0;
    end else begin
      rack_q <= ram_rd_o;
      wack_q <= 1'b0;
      if (dly_q) begin
        we_q   <= 1'b0;
        dly_q  <= 1'b0;
        wack_q <= 1'b1;
      end else if (wr_start_i && sel_i) begin
        we_q  <= 1'b1;
        dly_q <= 1'b1;
      end
    end
  end

  assign ram_we_o = we_q;
  assign rd_ack_o = rack_q;
  assign wr_ack_o = wack_q;

  AST_RAM_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> (!ram_we_o && wr_ack_o)); // R6
  AST_RAM_RD_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |-> $past(ram_rd_o)); // R5
endmodule

// File: rtl/regbank_subbus.sv
module regbank_subbus (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_start_i,
  input  logic wr_start_i,
  input  logic sel_i,
  input  logic sub_ack_i,
  output logic cyc_o,
  output logic we_o,
  output logic ack_o
);
  logic rd_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else if (cyc_o) begin
      if (sub_ack_i) begin
        rd_q <= 1'b0;
        wr_q <= 1'b0;
      end
    end else if (sel_i) begin
      rd_q <= rd_start_i;
      wr_q <= wr_start_i;
    end
  end

  assign cyc_o = rd_q | wr_q;
  assign we_o  = wr_q;
  assign ack_o = cyc_o & sub_ack_i;

  AST_SUB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && !sub_ack_i) |=> (cyc_o && $stable(we_o))); // R7
  AST_SUB_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && sub_ack_i) |=> !cyc_o); // R7
endmodule

// File: rtl/regbank_slave.sv
module regbank_slave
  import regbank_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int N_RW     = 2,
  parameter int REG_AW   = 2,
  parameter int REG_BASE = 0,
  parameter int RAM_AW   = 4,
  parameter int RAM_BASE = 16,
  parameter int SUB_AW   = 7,
  parameter int SUB_BASE = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wb_cyc_i,
  input  logic               wb_stb_i,
  input  logic               wb_we_i,
  input  logic [AW-1:0]      wb_adr_i,
  input  logic [DW-1:0]      wb_dat_i,
  output logic               wb_ack_o,
  output logic [DW-1:0]      wb_dat_o,
  input  logic [DW-1:0]      status_i,
  output logic [N_RW*DW-1:0] ctrl_o,
  output logic [DW-1:0]      cmd_o,
  output logic [RAM_AW-1:0]  ram_adr_o,
  output logic [DW-1:0]      ram_dat_o,
  output logic               ram_rd_o,
  output logic               ram_we_o,
  input  logic [DW-1:0]      ram_dat_i,
  output logic               sub_cyc_o,
  output logic               sub_stb_o,
  output logic               sub_we_o,
  output logic [DW/8-1:0]    sub_sel_o,
  output logic [SUB_AW-1:0]  sub_adr_o,
  output logic [DW-1:0]      sub_dat_o,
  input  logic               sub_ack_i,
  input  logic [DW-1:0]      sub_dat_i
);
  tgt_e          tgt;
  logic          busy_q, start, rd_start, wr_start;
  logic          loc_rd, loc_wr, reg_wr;
  logic [DW-1:0] rval, rdat_q;
  logic          rack_q, wack_q;
  logic          ram_rack, ram_wack, sub_ack;
  logic          sub_cyc;

  regbank_decode #(
    .AW(AW), .REG_AW(REG_AW), .REG_BASE(REG_BASE), .RAM_AW(RAM_AW),
    .RAM_BASE(RAM_BASE), .SUB_AW(SUB_AW), .SUB_BASE(SUB_BASE)
  ) u_dec (.adr_i(wb_adr_i), .tgt_o(tgt));

  // one access in flight; a new one is taken only after the acknowledge
  assign start    = wb_cyc_i & wb_stb_i & ~busy_q;
  assign rd_start = start & ~wb_we_i;
  assign wr_start = start &  wb_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_q <= 1'b0;
    else if (start)    busy_q <= 1'b1;
    else if (wb_ack_o) busy_q <= 1'b0;
  end

  // local registers and unmapped holes share the one-cycle path
  assign loc_rd = rd_start & (tgt == TGT_REG || tgt == TGT_NONE);
  assign loc_wr = wr_start & (tgt == TGT_REG || tgt == TGT_NONE);
  assign reg_wr = wr_start & (tgt == TGT_REG);

  regbank_regs #(.DW(DW), .REG_AW(REG_AW), .N_RW(N_RW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i    (reg_wr),
    .idx_i   (wb_adr_i[REG_AW-1:0]),
    .wdat_i  (wb_dat_i),
    .status_i,
    .ctrl_o,
    .cmd_o,
    .rval_o  (rval)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdat_q <= '0;
      rack_q <= 1'b0;
      wack_q <= 1'b0;
    end else begin
      rack_q <= loc_rd;
      wack_q <= loc_wr;
      if (loc_rd) rdat_q <= (tgt == TGT_REG) ? rval : '0;
    end
  end

  regbank_ram_port u_ram (
    .clk_i, .rst_ni,
    .rd_start_i (rd_start),
    .wr_start_i (wr_start),
    .sel_i      (tgt == TGT_RAM),
    .ram_rd_o,
    .ram_we_o,
    .rd_ack_o   (ram_rack),
    .wr_ack_o   (ram_wack)
  );
  assign ram_adr_o = wb_adr_i[RAM_AW-1:0];
  assign ram_dat_o = wb_dat_i;

  regbank_subbus u_sub (
    .clk_i, .rst_ni,
    .rd_start_i (rd_start),
    .wr_start_i (wr_start),
    .sel_i      (tgt == TGT_SUB),
    .sub_ack_i,
    .cyc_o      (sub_cyc),
    .we_o       (sub_we_o),
    .ack_o      (sub_ack)
  );
  assign sub_cyc_o = sub_cyc;
  assign sub_stb_o = sub_cyc;
  assign sub_sel_o = '1;
  assign sub_adr_o = wb_adr_i[SUB_AW-1:0];
  assign sub_dat_o = wb_dat_i;

  assign wb_ack_o = rack_q | wack_q | ram_rack | ram_wack | sub_ack;

  always_comb begin
    if (sub_cyc && !sub_we_o) wb_dat_o = sub_dat_i;
    else if (ram_rack)        wb_dat_o = ram_dat_i;
    else                      wb_dat_o = rdat_q;
  end

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o); // R9
  AST_ACK_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rack_q, wack_q, ram_rack, ram_wack, sub_ack})); // R9
  AST_LOC_RD_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rack_q |-> $past(wb_cyc_i && wb_stb_i && !wb_we_i)); // R3
  AST_RAM_RD_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd_o |=> wb_ack_o); // R5
  AST_SUB_ACK_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_cyc_o && sub_ack_i) |-> wb_ack_o); // R8
endmodule

// File: tb/regbank_slave_test.sv
module regbank_slave_test;
  localparam int AW = 8, DW = 32, N_RW = 2, RAM_AW = 4, SUB_AW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [AW-1:0] wb_adr = '0;
  logic [DW-1:0] wb_dat = '0;
  logic wb_ack;
  logic [DW-1:0] wb_rdat;
  logic [DW-1:0] status = 32'hC0DE_1234;
  logic [N_RW*DW-1:0] ctrl;
  logic [DW-1:0] cmd;
  logic [RAM_AW-1:0] ram_adr;
  logic [DW-1:0] ram_wdat, ram_q;
  logic ram_rd, ram_we;
  logic sub_cyc, sub_stb, sub_we, sub_ack;
  logic [DW/8-1:0] sub_sel;
  logic [SUB_AW-1:0] sub_adr;
  logic [DW-1:0] sub_wdat, sub_rdat;

  always #5 clk = ~clk;

  regbank_slave uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we),
    .wb_adr_i(wb_adr), .wb_dat_i(wb_dat), .wb_ack_o(wb_ack), .wb_dat_o(wb_rdat),
    .status_i(status), .ctrl_o(ctrl), .cmd_o(cmd),
    .ram_adr_o(ram_adr), .ram_dat_o(ram_wdat), .ram_rd_o(ram_rd), .ram_we_o(ram_we),
    .ram_dat_i(ram_q),
    .sub_cyc_o(sub_cyc), .sub_stb_o(sub_stb), .sub_we_o(sub_we), .sub_sel_o(sub_sel),
    .sub_adr_o(sub_adr), .sub_dat_o(sub_wdat), .sub_ack_i(sub_ack), .sub_dat_i(sub_rdat)
  );

  // behavioural RAM stub: synchronous read, data one cycle after the enable
  logic [DW-1:0] ram_mem [16];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) ram_mem[i] <= 32'h5A00_0000 + i;
      ram_q <= '0;
    end else begin
      if (ram_we) ram_mem[ram_adr] <= ram_wdat;
      if (ram_rd) ram_q <= ram_mem[ram_adr];
    end
  end

  // behavioural sub-bus stub: acknowledges in its third cycle of cyc
  logic [DW-1:0] sub_mem [128];
  logic [1:0] wc;
  assign sub_ack  = sub_cyc && wc == 2'd2;
  assign sub_rdat = sub_mem[sub_adr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) sub_mem[i] <= 32'hA500_0000 + i;
      wc <= '0;
    end else begin
      wc <= sub_cyc ? wc + 2'd1 : 2'd0;
      if (sub_ack && sub_we) sub_mem[sub_adr] <= sub_wdat;
    end
  end

  int cyc_n = 0;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  int we_cnt = 0, we_cyc = -1;
  always @(negedge clk) if (ram_we) begin we_cnt++; we_cyc = cyc_n; end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    logic [DW-1:0] dat;
    bit            rd;
    int            lat;
    string         req;
    int            t0;
  } exp_t;
  exp_t sb_q[$];

  initial forever begin
    exp_t e;
    @(negedge clk);
    if (rst_n && wb_ack) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9 unexpected ack: actual 1 expected 0");
      end else begin
        e = sb_q.pop_front();
        chk(e.req, "ack latency", 64'(cyc_n - e.t0), 64'(e.lat));
        if (e.rd) chk(e.req, "read data", 64'(wb_rdat), 64'(e.dat));
      end
    end
  end

  int last_t0;
  logic rd_seen, s_cyc, s_stb, s_we;
  logic [DW/8-1:0] s_sel;
  logic [SUB_AW-1:0] s_adr;
  logic [DW-1:0] s_dat;

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] exp, input int lat, input string req);
    exp_t e;
    bit got = 0;
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = a; wb_dat = d;
    e.dat = exp; e.rd = !we; e.lat = lat; e.req = req; e.t0 = cyc_n;
    last_t0 = cyc_n;
    sb_q.push_back(e);
    #1 rd_seen = ram_rd;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (wb_ack) begin got = 1; break; end
    end
    s_cyc = sub_cyc; s_stb = sub_stb; s_we = sub_we; s_sel = sub_sel; s_adr = sub_adr; s_dat = sub_wdat;
    wb_cyc = 0; wb_stb = 0;
    if (!got) begin
      n_chk++; n_fail++;
      $display("FAIL %s no ack: actual 0 expected 1", req);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset ack", 64'(wb_ack), 64'd0);
    chk("R9", "reset ctrl", 64'(ctrl), 64'd0);
    chk("R9", "reset cmd", 64'(cmd), 64'd0);
    chk("R9", "reset ram_we", 64'(ram_we), 64'd0);
    chk("R9", "reset sub_cyc", 64'(sub_cyc), 64'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3 control registers
    access(0, 8'd0, '0, 32'h0, 1, "R3");
    access(1, 8'd0, 32'h1111_0001, '0, 1, "R3");
    access(1, 8'd1, 32'h2222_0002, '0, 1, "R3");
    access(0, 8'd0, '0, 32'h1111_0001, 1, "R3");
    access(0, 8'd1, '0, 32'h2222_0002, 1, "R3");
    chk("R3", "ctrl_o", 64'(ctrl), 64'h2222_0002_1111_0001);

    // R4 status word: read-only
    access(0, 8'd2, '0, 32'hC0DE_1234, 1, "R4");
    access(1, 8'd2, 32'hFFFF_FFFF, '0, 1, "R4");
    status = 32'h0BEE_F00D;
    access(0, 8'd2, '0, 32'h0BEE_F00D, 1, "R4");
    chk("R4", "ctrl after ro write", 64'(ctrl), 64'h2222_0002_1111_0001);
    // R4 command word: write-only
    access(1, 8'd3, 32'h3333_0003, '0, 1, "R4");
    chk("R4", "cmd_o", 64'(cmd), 64'h3333_0003);
    access(0, 8'd3, '0, 32'h0, 1, "R4");

    // R1 unmapped reads at window edges
    access(0, 8'd4, '0, 32'h0, 1, "R1");
    chk("R5", "ram_rd on unmapped", 64'(rd_seen), 64'd0);
    access(0, 8'd15, '0, 32'h0, 1, "R1");
    access(0, 8'd32, '0, 32'h0, 1, "R1");
    access(0, 8'd127, '0, 32'h0, 1, "R1");
    access(0, 8'd1, '0, 32'h2222_0002, 1, "R3");
    chk("R5", "ram_rd on register read", 64'(rd_seen), 64'd0);

    // R2 unmapped writes leave everything alone
    w0 = we_cnt;
    access(1, 8'd5, 32'hDEAD_DEAD, '0, 1, "R2");
    access(1, 8'd33, 32'hBEEF_BEEF, '0, 1, "R2");
    chk("R2", "ctrl unchanged", 64'(ctrl), 64'h2222_0002_1111_0001);
    chk("R2", "cmd unchanged", 64'(cmd), 64'h3333_0003);
    chk("R2", "no ram write", 64'(we_cnt), 64'(w0));
    access(0, 8'd16, '0, 32'h5A00_0000, 1, "R2");
    access(0, 8'd129, '0, 32'hA500_0001, 3, "R2");

    // R5 RAM reads
    access(0, 8'd16, '0, 32'h5A00_0000, 1, "R5");
    chk("R5", "ram_rd in accept cycle", 64'(rd_seen), 64'd1);
    access(0, 8'd31, '0, 32'h5A00_000F, 1, "R5");
    chk("R5", "ram_rd last word", 64'(rd_seen), 64'd1);

    // R6 RAM write sequencing
    w0 = we_cnt;
    access(1, 8'd20, 32'h0BAD_F00D, '0, 2, "R6");
    chk("R6", "one ram_we pulse", 64'(we_cnt), 64'(w0 + 1));
    chk("R6", "ram_we cycle", 64'(we_cyc), 64'(last_t0 + 1));
    access(0, 8'd20, '0, 32'h0BAD_F00D, 1, "R6");

    // R7/R8 sub-bus forwarding
    access(0, 8'd128, '0, 32'hA500_0000, 3, "R8");
    chk("R7", "cyc held", 64'(s_cyc), 64'd1);
    chk("R7", "stb held", 64'(s_stb), 64'd1);
    chk("R7", "we on read", 64'(s_we), 64'd0);
    chk("R7", "sel", 64'(s_sel), 64'hF);
    chk("R7", "offset", 64'(s_adr), 64'd0);
    access(0, 8'd255, '0, 32'hA500_007F, 3, "R8");
    chk("R7", "offset top", 64'(s_adr), 64'd127);
    access(1, 8'd130, 32'h1234_5678, '0, 3, "R8");
    chk("R7", "we on write", 64'(s_we), 64'd1);
    chk("R7", "write data", 64'(s_dat), 64'h1234_5678);
    chk("R7", "offset write", 64'(s_adr), 64'd2);
    chk("R5", "ram_rd on sub read", 64'(rd_seen), 64'd0);
    access(0, 8'd130, '0, 32'h1234_5678, 3, "R8");
    @(negedge clk);
    chk("R7", "cyc released", 64'(sub_cyc), 64'd0);

    repeat (4) @(negedge clk);
    chk("R9", "all acks matched", 64'(sb_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule